// File: doc/BRIEF.md
# Vectored Interrupt Source Router

The block takes level interrupt requests from seven on-chip sources and turns them into level requests on eight output lines toward a downstream interrupt presenter. Requests 0 and 1 are served together by one vector. Each of the other five requests has a vector of its own, which gives six vectors in all. Each vector is a 64-bit word with three fields: a destination server, a priority and a 3-bit source number. The source number picks the output line that the vector's request drives. A priority of all ones masks the vector. The block records every request level in one of two status words. For each vector it keeps a pending flag, which stands for "asserted and not masked".

Software uses a simple write/read port. A write to a vector word updates the routing fields and, in the next cycle, sends a routing update to the presenter. That update carries the output line, the server with its two link-pointer bits dropped, and the priority. A write that names source 7 is stored in the vector word but sends no update to the presenter. Reads return the vector words and the two status words.

Address map (word addresses): 0 to 5 are vectors 0 to 5. Address 6 is the control/status word and address 7 is the interrupt status word. Every other address is unmapped.

Top module: `irq_source_router`

## Requirements
- R1: After reset the following hold. Vector v reads priority 0xFF in bits 39:32, source v in bits 31:29, and zero in every other bit, pending included. Both status words read 0. All output lines are low.
- R2: A write to vector address v replaces the server (bits 55:40), the priority (39:32) and the source (31:29). It keeps the pending bit (24). Every other bit reads back 0 whatever was written.
- R3: Status bits follow the request inputs one cycle later. Request 0 drives bit 47 and request 1 drives bit 46 of the control/status word (address 6). Requests 2 to 6 drive bits 36, 35, 34, 33 and 32 of the interrupt status word (address 7). Writes to addresses 6 and 7 have no effect.
- R4: Output line L is high one cycle after any request of a vector whose source field equals L is high. The mask does not gate it. The line shared by requests 0 and 1 falls only when both are low.
- R5: When any request of a vector changes, that vector's pending bit becomes "level asserted AND priority not 0xFF".
- R6: A write that sets priority 0xFF clears pending. A write with any other priority does not set pending.
- R7: A vector write with source below 7 gives a one-cycle route_valid_o in the next cycle. The update carries route_line_o = source, route_server_o = server bits 55:42 (the server shifted right by 2) and route_prio_o = priority.
- R8: A vector write with source 7 gives no routing update. The field is still stored, so the vector then drives line 7.
- R9: Reads of unmapped addresses return all ones. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 7 | Level interrupt requests |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Read data for reg_addr_i (combinational) |
| irq_line_o | output | 8 | Level request lines to the presenter |
| route_valid_o | output | 1 | Routing update strobe |
| route_line_o | output | 3 | Output line of the update |
| route_server_o | output | 14 | Destination server without link pointer |
| route_prio_o | output | 8 | Priority of the update |

## Verification
The bench builds the block with its default parameters: seven request inputs and a 4-bit address. Eight addresses beyond the map can therefore be reached, and so can source value 7, which is rejected for routing but still drives the last output line. These settings give access to the shared pair of requests on one vector, to the masked and unmasked pending transitions, and to writes that try to set the bits a vector ignores.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int WORD_W     = 64;
    localparam int SRV_LO     = 40;
    localparam int SRV_W      = 16;
    localparam int PRI_LO     = 32;
    localparam int PRI_W      = 8;
    localparam int SRC_LO     = 29;
    localparam int SRC_W      = 3;
    localparam int PEND_BIT   = 24;
    localparam int LINK_W     = 2;
    localparam int PAIR_CNT   = 2;
    localparam int CTRL_TOP   = 47;
    localparam int STAT_TOP   = 36;
    localparam logic [PRI_W-1:0] PRI_MASKED = '1;

    typedef struct packed {
        logic [SRV_W-1:0] server;
        logic [PRI_W-1:0] prio;
        logic [SRC_W-1:0] src;
        logic             pend;
    } vec_fields_t;

    typedef struct packed {
        logic                      valid;
        logic [SRC_W-1:0]          line;
        logic [SRV_W-LINK_W-1:0]   server;
        logic [PRI_W-1:0]          prio;
    } route_t;

    function automatic logic [WORD_W-1:0] pack_vec(input vec_fields_t f);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SRV_LO +: SRV_W] = f.server;
        w[PRI_LO +: PRI_W] = f.prio;
        w[SRC_LO +: SRC_W] = f.src;
        w[PEND_BIT]        = f.pend;
        return w;
    endfunction

    function automatic vec_fields_t unpack_vec(input logic [WORD_W-1:0] w);
        vec_fields_t f;
        f.server = w[SRV_LO +: SRV_W];
        f.prio   = w[PRI_LO +: PRI_W];
        f.src    = w[SRC_LO +: SRC_W];
        f.pend   = w[PEND_BIT];
        return f;
    endfunction

    // requests of the leading pair share vector 0
    function automatic int vec_of_req(input int i);
        return (i < PAIR_CNT) ? 0 : i - PAIR_CNT + 1;
    endfunction

    // bit position in the control word (pair) or the status word (rest)
    function automatic int stat_bit_of_req(input int i);
        return (i < PAIR_CNT) ? CTRL_TOP - i : STAT_TOP - (i - PAIR_CNT);
    endfunction

endpackage

// File: rtl/irq_vec_slot.sv
module irq_vec_slot
    import irq_router_pkg::*;
#(
    parameter int INDEX = 0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              evt_i,
    input  logic              level_i,
    output vec_fields_t       fields_o
);

    vec_fields_t cur_q;
    vec_fields_t nxt;
    vec_fields_t incoming;

    assign incoming = unpack_vec(wdata_i);

    always_comb begin
        nxt = cur_q;
        if (wr_i) begin
            nxt.server = incoming.server;
            nxt.prio   = incoming.prio;
            nxt.src    = incoming.src;
            if (nxt.prio == PRI_MASKED) begin
                nxt.pend = 1'b0;
            end
        end
        if (evt_i) begin
            nxt.pend = level_i && (nxt.prio != PRI_MASKED);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q <= '{server: '0, prio: PRI_MASKED, src: SRC_W'(INDEX), pend: 1'b0};
        end else begin
            cur_q <= nxt;
        end
    end

    assign fields_o = cur_q;

endmodule

// File: rtl/irq_status_capture.sv
module irq_status_capture
    import irq_router_pkg::*;
#(
    parameter int NUM_REQ = 7
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_REQ-1:0] req_i,
    output logic [NUM_REQ-1:0] req_q_o,
    output logic [WORD_W-1:0]  ctrl_word_o,
    output logic [WORD_W-1:0]  stat_word_o
);

    logic [NUM_REQ-1:0] req_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_q <= '0;
        end else begin
            req_q <= req_i;
        end
    end

    always_comb begin
        ctrl_word_o = '0;
        stat_word_o = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (i < PAIR_CNT) begin
                ctrl_word_o[stat_bit_of_req(i)] = req_q[i];
            end else begin
                stat_word_o[stat_bit_of_req(i)] = req_q[i];
            end
        end
    end

    assign req_q_o = req_q;

endmodule

// File: rtl/irq_line_select.sv
module irq_line_select
    import irq_router_pkg::*;
#(
    parameter int NUM_VEC   = 6,
    parameter int NUM_LINES = 8
) (
    input  logic [NUM_VEC-1:0]            level_i,
    input  logic [NUM_VEC-1:0][SRC_W-1:0] src_i,
    output logic [NUM_LINES-1:0]          line_o
);

    always_comb begin
        line_o = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                if (level_i[v] && (src_i[v] == SRC_W'(l))) begin
                    line_o[l] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irq_route_notify.sv
module irq_route_notify
    import irq_router_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        accept_i,
    input  vec_fields_t wf_i,
    output route_t      route_o
);

    route_t q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
        end else begin
            q.valid  <= accept_i;
            if (accept_i) begin
                q.line   <= wf_i.src;
                q.server <= wf_i.server[SRV_W-1:LINK_W];
                q.prio   <= wf_i.prio;
            end
        end
    end

    assign route_o = q;

endmodule

// File: rtl/irq_source_router.sv
module irq_source_router
    import irq_router_pkg::*;
#(
    parameter int NUM_REQ = 7,
    parameter int ADDR_W  = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic [NUM_REQ-1:0]       req_i,
    input  logic                     reg_we_i,
    input  logic [ADDR_W-1:0]        reg_addr_i,
    input  logic [WORD_W-1:0]        reg_wdata_i,
    output logic [WORD_W-1:0]        reg_rdata_o,
    output logic [(1<<SRC_W)-1:0]    irq_line_o,
    output logic                     route_valid_o,
    output logic [SRC_W-1:0]         route_line_o,
    output logic [SRV_W-LINK_W-1:0]  route_server_o,
    output logic [PRI_W-1:0]         route_prio_o
);

    localparam int NUM_VEC   = NUM_REQ - PAIR_CNT + 1;
    localparam int NUM_LINES = 1 << SRC_W;
    localparam int ADDR_CTRL = NUM_VEC;
    localparam int ADDR_STAT = NUM_VEC + 1;
    localparam int SRC_LIMIT = NUM_LINES - 1;

    logic [NUM_REQ-1:0]            req_q;
    logic [WORD_W-1:0]             ctrl_word;
    logic [WORD_W-1:0]             stat_word;
    logic [NUM_VEC-1:0]            level_q;
    logic [NUM_VEC-1:0]            level_new;
    logic [NUM_VEC-1:0]            evt;
    logic [NUM_VEC-1:0]            wr_vec;
    logic [NUM_VEC-1:0][SRC_W-1:0] src_sel;
    logic [NUM_VEC-1:0][WORD_W-1:0] vec_word;
    vec_fields_t                   fields [NUM_VEC];
    vec_fields_t                   wf;
    logic                          accept;
    route_t                        route;

    irq_status_capture #(.NUM_REQ(NUM_REQ)) status_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .req_i       (req_i),
        .req_q_o     (req_q),
        .ctrl_word_o (ctrl_word),
        .stat_word_o (stat_word)
    );

    // per-vector level now, level last cycle, and change event
    always_comb begin
        level_q   = '0;
        level_new = '0;
        evt       = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            level_q[vec_of_req(i)]   = level_q[vec_of_req(i)]   | req_q[i];
            level_new[vec_of_req(i)] = level_new[vec_of_req(i)] | req_i[i];
            evt[vec_of_req(i)]       = evt[vec_of_req(i)]       | (req_i[i] ^ req_q[i]);
        end
    end

    assign wf = unpack_vec(reg_wdata_i);

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        assign wr_vec[v] = reg_we_i && (reg_addr_i == ADDR_W'(v));

        irq_vec_slot #(.INDEX(v)) slot_i (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .wr_i     (wr_vec[v]),
            .wdata_i  (reg_wdata_i),
            .evt_i    (evt[v]),
            .level_i  (level_new[v]),
            .fields_o (fields[v])
        );

        assign src_sel[v]  = fields[v].src;
        assign vec_word[v] = pack_vec(fields[v]);
    end

    irq_line_select #(.NUM_VEC(NUM_VEC), .NUM_LINES(NUM_LINES)) lines_i (
        .level_i (level_q),
        .src_i   (src_sel),
        .line_o  (irq_line_o)
    );

    assign accept = (|wr_vec) && (wf.src < SRC_W'(SRC_LIMIT));

    irq_route_notify notify_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .accept_i (accept),
        .wf_i     (wf),
        .route_o  (route)
    );

    assign route_valid_o  = route.valid;
    assign route_line_o   = route.line;
    assign route_server_o = route.server;
    assign route_prio_o   = route.prio;

    always_comb begin
        reg_rdata_o = '1;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (reg_addr_i == ADDR_W'(v)) begin
                reg_rdata_o = vec_word[v];
            end
        end
        if (reg_addr_i == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata_o = ctrl_word;
        end
        if (reg_addr_i == ADDR_W'(ADDR_STAT)) begin
            reg_rdata_o = stat_word;
        end
    end

endmodule

// File: rtl/irq_source_router_chk.sv
module irq_source_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_REQ = 7,
    parameter int NUM_VEC = 6,
    parameter int ADDR_W  = 4
) (
    input logic                      clk_i,
    input logic                      rst_i,
    input logic [NUM_REQ-1:0]        req_i,
    input logic                      reg_we_i,
    input logic [ADDR_W-1:0]         reg_addr_i,
    input logic [WORD_W-1:0]         reg_wdata_i,
    input logic [(1<<SRC_W)-1:0]     irq_line_o,
    input logic                      route_valid_o,
    input logic [SRC_W-1:0]          route_line_o,
    input logic [NUM_VEC-1:0][WORD_W-1:0] vec_word
);

    logic vec_wr;
    assign vec_wr = reg_we_i && (reg_addr_i < ADDR_W'(NUM_VEC));

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_pend
        // R6
        masked_no_pend_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (vec_word[v][PRI_LO +: PRI_W] == PRI_MASKED) |-> !vec_word[v][PEND_BIT]);
    end

    // R4
    line_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i == '0) |=> (irq_line_o == '0));

    // R7
    route_after_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (vec_wr && (reg_wdata_i[SRC_LO +: SRC_W] != '1))
        |=> (route_valid_o && (route_line_o == $past(reg_wdata_i[SRC_LO +: SRC_W]))));

    // R8
    bad_src_no_route_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (vec_wr && (reg_wdata_i[SRC_LO +: SRC_W] == '1)) |=> !route_valid_o);

    // R7
    route_needs_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !vec_wr |=> !route_valid_o);

endmodule

bind irq_source_router irq_source_router_chk #(
    .NUM_REQ (NUM_REQ),
    .NUM_VEC (NUM_VEC),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .req_i         (req_i),
    .reg_we_i      (reg_we_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wdata_i   (reg_wdata_i),
    .irq_line_o    (irq_line_o),
    .route_valid_o (route_valid_o),
    .route_line_o  (route_line_o),
    .vec_word      (vec_word)
);

// File: tb/irq_source_router_tb_top.sv
module irq_source_router_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] PEND = 64'h0000_0000_0100_0000;

    typedef struct packed {
        logic [3:0]  addr;
        logic [63:0] wdata;
        logic [63:0] exp;
    } tv_t;

    localparam tv_t [4:0] TABLE = '{
        '{4'd0,  64'hFF12_3456_7890_ABCD, 64'h0012_3456_6000_0000},
        '{4'd3,  64'h0000_ABCD_10FF_FFFF, 64'h0000_ABCD_0000_0000},
        '{4'd6,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
        '{4'd9,  64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF},
        '{4'd5,  64'h0000_0001_FFE0_0000, 64'h0000_0001_E000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  req = '0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [7:0]  lines;
    logic        r_valid;
    logic [2:0]  r_line;
    logic [13:0] r_server;
    logic [7:0]  r_prio;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_source_router dut_i (
        .clk_i          (clk),
        .rst_i          (rst),
        .req_i          (req),
        .reg_we_i       (we),
        .reg_addr_i     (addr),
        .reg_wdata_i    (wdata),
        .reg_rdata_o    (rdata),
        .irq_line_o     (lines),
        .route_valid_o  (r_valid),
        .route_line_o   (r_line),
        .route_server_o (r_server),
        .route_prio_o   (r_prio)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [63:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic set_req(input int i, input logic val);
        @(negedge clk);
        req[i] = val;
        @(negedge clk);
    endtask

    function automatic logic [63:0] vword(input logic [15:0] srv, input logic [7:0] pr, input logic [2:0] src);
        return (64'(srv) << 40) | (64'(pr) << 32) | (64'(src) << 29);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int v = 0; v < 6; v++) begin
            rd("R1 vector reset", 4'(v), vword(16'h0, 8'hFF, 3'(v)));
        end
        rd("R1 ctrl reset", 4'd6, 64'h0);
        rd("R1 stat reset", 4'd7, 64'h0);
        chk("R1 lines reset", 64'(lines), 64'h0);
        chk("R1 route reset", 64'(r_valid), 64'h0);

        // table walk: R2 field masking, R3/R9 ignored writes, R7/R8 routing
        for (int k = 4; k >= 0; k--) begin
            logic exp_route;
            wr(TABLE[k].addr, TABLE[k].wdata);
            exp_route = (TABLE[k].addr < 4'd6) && (TABLE[k].wdata[31:29] != 3'd7);
            chk("R7 R8 route valid", 64'(r_valid), 64'(exp_route));
            if (exp_route) begin
                chk("R7 route line", 64'(r_line), 64'(TABLE[k].wdata[31:29]));
                chk("R7 route server", 64'(r_server), 64'(TABLE[k].wdata[55:42]));
                chk("R7 route prio", 64'(r_prio), 64'(TABLE[k].wdata[39:32]));
            end
            rd("R2 R3 R9 table readback", TABLE[k].addr, TABLE[k].exp);
        end

        // directed tests from a clean state
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;

        set_req(2, 1'b1);
        rd("R3 stat bit36", 4'd7, 64'h1 << 36);
        chk("R4 line1 masked vector", 64'(lines), 64'h02);
        rd("R5 masked no pend", 4'd1, vword(16'h0, 8'hFF, 3'd1));

        wr(4'd1, vword(16'h0, 8'h10, 3'd1));
        rd("R6 unmask write no pend", 4'd1, vword(16'h0, 8'h10, 3'd1));
        set_req(2, 1'b0);
        chk("R4 line1 low", 64'(lines), 64'h00);
        rd("R5 pend low", 4'd1, vword(16'h0, 8'h10, 3'd1));
        set_req(2, 1'b1);
        rd("R5 pend set", 4'd1, vword(16'h0, 8'h10, 3'd1) | PEND);
        wr(4'd1, vword(16'h0, 8'hFF, 3'd1));
        rd("R6 mask write clears", 4'd1, vword(16'h0, 8'hFF, 3'd1));
        chk("R4 line ignores mask", 64'(lines), 64'h02);
        set_req(2, 1'b0);

        wr(4'd0, vword(16'h0, 8'h20, 3'd4));
        @(negedge clk); req[0] = 1'b1; req[1] = 1'b1;
        @(negedge clk);
        rd("R3 ctrl pair bits", 4'd6, (64'h1 << 47) | (64'h1 << 46));
        chk("R4 line4 pair", 64'(lines), 64'h10);
        rd("R5 pair pend", 4'd0, vword(16'h0, 8'h20, 3'd4) | PEND);
        set_req(0, 1'b0);
        rd("R3 ctrl bit46 only", 4'd6, 64'h1 << 46);
        chk("R4 shared line held", 64'(lines), 64'h10);
        rd("R5 pend held by partner", 4'd0, vword(16'h0, 8'h20, 3'd4) | PEND);
        set_req(1, 1'b0);
        chk("R4 shared line drops", 64'(lines), 64'h00);
        rd("R5 pend cleared", 4'd0, vword(16'h0, 8'h20, 3'd4));

        wr(4'd2, vword(16'h00F7, 8'h33, 3'd6));
        chk("R7 route valid", 64'(r_valid), 64'h1);
        chk("R7 route line", 64'(r_line), 64'd6);
        chk("R7 server shifted", 64'(r_server), 64'h3D);
        chk("R7 prio", 64'(r_prio), 64'h33);

        wr(4'd4, vword(16'h0, 8'h40, 3'd7));
        chk("R8 no route", 64'(r_valid), 64'h0);
        rd("R8 src7 stored", 4'd4, vword(16'h0, 8'h40, 3'd7));
        set_req(5, 1'b1);
        chk("R8 line7 driven", 64'(lines), 64'h80);
        rd("R3 stat bit33", 4'd7, 64'h1 << 33);

        wr(4'd7, 64'hFFFF_FFFF_FFFF_FFFF);
        rd("R3 stat write ignored", 4'd7, 64'h1 << 33);
        wr(4'd12, 64'hFFFF_FFFF_FFFF_FFFF);
        rd("R9 unmapped read", 4'd12, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R9 lines unchanged", 64'(lines), 64'h80);
        for (int v = 0; v < 6; v++) begin
            logic [63:0] e;
            case (v)
                0: e = vword(16'h0, 8'h20, 3'd4);
                1: e = vword(16'h0, 8'hFF, 3'd1);
                2: e = vword(16'h00F7, 8'h33, 3'd6);
                4: e = vword(16'h0, 8'h40, 3'd7) | PEND;
                default: e = vword(16'h0, 8'hFF, 3'(v));
            endcase
            rd("R9 vectors untouched", 4'(v), e);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule